// File: doc/BRIEF.md
# Pulse-Interval Nibble Receiver

This block recovers data that a sender encodes only in the timing between trigger events on one wire. It passes the trigger input through a two-flop synchroniser, takes each rising edge as an event and counts the clock ticks from one event to the next. Each interval is converted back into a symbol value.

The conversion uses a 40-tick minimum gap and a step of 4 ticks per symbol value. The interval is rounded to the nearest step, so a sender's jitter of one tick either way still decodes correctly.

Symbols 0 to 15 are data nibbles. Two data nibbles in a row form one byte, which is presented with a one-cycle valid strobe. Symbol 16 is the idle filler a sender puts on the line when it has nothing to send. It carries no data, and it realigns the pairing so that the next data nibble starts a fresh byte. Intervals that are too short or too long give a one-cycle error pulse and also restart the pairing. The receiver runs continuously from reset and needs no start command.

Top module: `pulse_gap_nibble_rx`

## Requirements
- R1: An interval of 40 + 4·s ticks between rising edges, with s in 0..15, decodes to data nibble s. The first data nibble of a pair is bits [7:4] of the byte and the second is bits [3:0]. The byte appears on `rx_byte` while `rx_valid` is high for exactly one cycle.
- R2: The interval is rounded to the nearest 4-tick step. An interval of 40 + 4·s ± 1 ticks decodes to s. The boundaries are: 38 ticks decodes to 0, and 105 ticks decodes to 16.
- R3: Symbol 16 (intervals of 102 to 105 ticks) produces neither `rx_valid` nor `rx_err`. After it, the next data nibble is taken as the high nibble of a new byte.
- R4: An interval shorter than 38 ticks raises `rx_err` for one cycle, produces no byte and restarts the pairing.
- R5: An interval that decodes above 16 (106 ticks or more) raises `rx_err` for one cycle, produces no byte and restarts the pairing.
- R6: The tick counter saturates and does not wrap. A silent gap of any length beyond the counter range (for example 348 ticks) decodes as an error, never as data.
- R7: The first rising edge after reset only starts timing. It produces neither a byte nor an error, whatever time has passed since reset.
- R8: During and immediately after reset, `rx_valid` and `rx_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of interval measurement |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Asynchronous trigger line |
| rx_byte | output | 8 | Most recently assembled byte |
| rx_valid | output | 1 | One-cycle strobe that marks a new byte on `rx_byte` |
| rx_err | output | 1 | One-cycle strobe for an interval that is out of range |

## Verification
The case that is hardest to reach from the ports is a silence longer than the counter's range. A wrapping counter would then return a plausible data value, so the fault would look like valid data. The stimulus holds the line quiet for 348 ticks, which is chosen so that a wrapped 8-bit count (92) would decode as nibble 13. Only saturation turns that gap into the expected error. Pairing realignment is also checked: a lone nibble is followed by an idle symbol or an error, then by a full byte. This catches a stale high nibble that leaks into the next byte.

// File: rtl/pulse_gap_nibble_rx.sv
`timescale 1ns/1ps
module pulse_gap_nibble_rx #(
  parameter int MIN_GAP = 40,
  parameter int STEP    = 4,
  parameter int SYM_W   = 4,
  parameter int CNT_W   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_in,
  output logic [7:0] rx_byte,
  output logic       rx_valid,
  output logic       rx_err
);
  localparam int LOW_LIM = MIN_GAP - STEP / 2;
  localparam int IDLE    = 2 ** SYM_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0]       sync;
  logic [CNT_W-1:0] cnt, ofs, sym;
  logic             armed, have_hi;
  logic [SYM_W-1:0] hi_nib;
  logic             edge_seen, short_gap, idle_sym, long_gap;

  assign edge_seen = sync[1] & ~sync[2];
  assign short_gap = cnt < CNT_W'(LOW_LIM);
  assign ofs       = cnt - CNT_W'(LOW_LIM);
  assign sym       = ofs / CNT_W'(STEP);
  assign idle_sym  = sym == CNT_W'(IDLE);
  assign long_gap  = sym > CNT_W'(IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync     <= '0;
      cnt      <= '0;
      armed    <= 1'b0;
      have_hi  <= 1'b0;
      hi_nib   <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
    end else begin
      sync     <= {sync[1:0], trig_in};
      rx_valid <= 1'b0;
      rx_err   <= 1'b0;
      if (edge_seen)             cnt <= CNT_W'(1);
      else if (cnt != CNT_MAX)   cnt <= cnt + 1'b1;
      if (edge_seen) begin
        armed <= 1'b1;
        if (armed) begin
          if (short_gap || long_gap) begin
            rx_err  <= 1'b1;
            have_hi <= 1'b0;
          end else if (idle_sym) begin
            have_hi <= 1'b0;
          end else if (!have_hi) begin
            hi_nib  <= sym[SYM_W-1:0];
            have_hi <= 1'b1;
          end else begin
            rx_byte  <= {hi_nib, sym[SYM_W-1:0]};
            rx_valid <= 1'b1;
            have_hi  <= 1'b0;
          end
        end
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid); // R1
  AST_ERR_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_err)); // R4
  AST_SHORT_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && armed && short_gap) |=> (rx_err && !rx_valid)); // R4
  AST_LONG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && armed && long_gap) |=> rx_err); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_seen && armed && idle_sym && !short_gap) |=> (!rx_valid && !rx_err)); // R3
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && !edge_seen) |=> cnt == CNT_MAX); // R6
  AST_FIRST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (!rx_valid && !rx_err)); // R7
endmodule

// File: tb/test_pulse_gap_nibble_rx.sv
`timescale 1ns/1ps
module test_pulse_gap_nibble_rx;
  logic clk = 0, rst_n = 0, trig_in = 0;
  logic [7:0] rx_byte;
  logic rx_valid, rx_err;
  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  string err_q[$];
  bit have_hi = 0;
  logic [3:0] hi = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pulse_gap_nibble_rx i_pulse_gap_nibble_rx (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // gap of n ticks from the previous rising edge, then a new rising edge held 3 cycles
  task automatic gap_rise(int n);
    repeat (n - 3) @(negedge clk);
    trig_in = 1;
    repeat (3) @(negedge clk);
    trig_in = 0;
  endtask

  task automatic sym(int s, int j, string tag);
    if (s < 16) begin
      if (have_hi) begin
        exp_q.push_back({hi, 4'(s)});
        tag_q.push_back(tag);
        have_hi = 0;
      end else begin
        hi = 4'(s);
        have_hi = 1;
      end
    end else have_hi = 0;
    gap_rise(40 + 4 * s + j);
  endtask

  task automatic bad(int n, string tag);
    err_q.push_back(tag);
    have_hi = 0;
    gap_rise(n);
  endtask

  task automatic send_byte(logic [7:0] b, string tag);
    sym(int'(b[7:4]), 0, tag);
    sym(int'(b[3:0]), 0, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (rx_valid) begin
        if (exp_q.size() == 0) check(0, "R1 unexpected byte", int'(rx_byte), 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rx_byte == e, t, int'(rx_byte), int'(e));
        end
      end
      if (rx_err) begin
        if (err_q.size() == 0) check(0, "R4/R5 unexpected error", 1, 0);
        else begin
          string t;
          t = err_q.pop_front();
          check(1, t, 1, 1);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (150000) @(negedge clk);
        check(0, "watchdog", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
      end
    join_none
    repeat (4) @(negedge clk);
    check(rx_valid == 0 && rx_err == 0, "R8 in reset", int'({rx_valid, rx_err}), 0);
    rst_n = 1;
    @(negedge clk);
    check(rx_valid == 0 && rx_err == 0, "R8 after reset", int'({rx_valid, rx_err}), 0);
    // R7: arm soon after reset; a short count since reset must not raise an error
    trig_in = 1;
    repeat (3) @(negedge clk);
    trig_in = 0;
    send_byte(8'hA5, "R1 byte A5");
    send_byte(8'h3C, "R1 byte 3C");
    send_byte(8'h00, "R1 byte 00");
    send_byte(8'hFF, "R1 byte FF");
    sym(5, 1, "R2 jitter +1");
    sym(10, -1, "R2 jitter -1");
    sym(0, -2, "R2 38 ticks");
    sym(16, 1, "R2 105 ticks idle");
    sym(9, -1, "R2 jitter");
    sym(6, 1, "R2 jitter 96");
    sym(7, 0, "R3");
    sym(16, 0, "R3 idle");
    sym(1, 0, "R3 realigned 12");
    sym(2, 0, "R3 realigned 12");
    sym(4, 0, "R4");
    bad(30, "R4 short gap");
    bad(37, "R4 37 ticks");
    send_byte(8'h68, "R4 realigned 68");
    sym(11, 0, "R5");
    bad(106, "R5 106 ticks");
    bad(200, "R5 200 ticks");
    send_byte(8'hC3, "R5 realigned C3");
    bad(348, "R6 saturated silence");
    send_byte(8'h7E, "R6 after silence");
    repeat (20) @(negedge clk);
    done = 1;
    check(exp_q.size() == 0, "R1 missing bytes", exp_q.size(), 0);
    check(err_q.size() == 0, "R4/R5 missing errors", err_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule